// File: doc/BRIEF.md
# Iterative Eight-Round Feistel Block Engine

The engine encrypts or decrypts a 16-bit block under a 32-bit key. The block is held as two bytes: the upper byte is the left half and the lower byte is the right half. The key is held as four byte subkeys. Subkey 0 is the most significant byte of the key and subkey 3 is the least significant byte. Each round steps a 16-bit running sum by a fixed constant. It then rewrites each half by adding (when encrypting) or subtracting (when decrypting) a mixing term taken from the other half. The mixing term is the XOR of three values:

- the other half shifted left by four, plus one subkey;
- the other half plus the low byte of the running sum;
- the other half shifted right by five, plus a second subkey.

A single mixing unit is shared between the two halves. A phase bit picks which half is written on each clock. A round therefore takes two clocks, and a whole operation takes sixteen.

A host pulses `start` with the operation, block and key present. These are latched on that edge. The result port shows the two half registers at all times. A one-cycle `done` marks the clock after the last half is written. The value then stays put until the next accepted start.

Top module: `feistel8_engine`

## Requirements
- R1: After the asynchronous active-low reset, `block_out` is 16'h0000 and `done` is 0. Asserting reset during an operation clears both at once.
- R2: Encryption (`decrypt`=0) of block 16'h1234 under key 32'h778CAE38 yields 16'hFD58.
- R3: In that encryption, two clocks after the accepted start, `block_out` reads 16'h20EB. This is the state after the first round.
- R4: One half changes per clock. When encrypting, the left half (`block_out[15:8]`) is written first, in the clock after the start edge, with left shift zero-filled by four and right shift zero-filled by five.
- R5: Decryption (`decrypt`=1) runs the rounds in reverse. The running sum starts at eight times the constant, the right half is written first, and both halves are updated by subtraction. Decrypting 16'hFD58 under the same key returns 16'h1234, and any encrypted block decrypts back to its plaintext.
- R6: `done` is high for exactly one clock. It is high on the 16th clock after the edge that accepted the start.
- R7: A `start` pulse while an operation is running has no effect on the result or on when it completes.
- R8: After `done`, `block_out` holds its value until the next accepted start.
- R9: Block, key and mode are captured at the accepted start. Changing those inputs during an operation does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | 0 encrypt, 1 decrypt; latched at start |
| block_in | input | 16 | Input block, left half in the upper byte |
| key_in | input | 32 | Key, subkey 0 in the upper byte |
| block_out | output | 16 | Current halves; the result once done |
| done | output | 1 | One-clock completion pulse |

## Verification
Both half registers are visible on `block_out` on every clock, so a wrong shift, subkey choice, sum term or update order shows at the port within one or two clocks of the first bad step. A wrong phase bit or round counter shifts the `done` pulse or changes the final value by clock 16. A reference model in the bench steps in lock-step with the design and compares both outputs on every clock. Any divergence is therefore reported on the first cycle in which it appears.

// File: rtl/feistel8_pkg.sv
package feistel8_pkg;
   typedef enum logic {OP_ENC = 1'b0, OP_DEC = 1'b1} op_e;
endpackage

// File: rtl/fc_mix.sv
module fc_mix #(
   parameter int W   = 8,
   parameter int SHL = 4,
   parameter int SHR = 5
) (
   input  logic [W-1:0] src,
   input  logic [W-1:0] ka,
   input  logic [W-1:0] kb,
   input  logic [W-1:0] salt,
   input  logic [W-1:0] tgt,
   input  logic         sub,
   output logic [W-1:0] result
);
   logic [W-1:0] up_t, dn_t, mid_t, mix;

   generate
      if (SHL == 0) begin : g_no_shl
         assign up_t = src + ka;
      end else begin : g_shl
         assign up_t = {src[W-1-SHL:0], {SHL{1'b0}}} + ka;
      end
      if (SHR == 0) begin : g_no_shr
         assign dn_t = src + kb;
      end else begin : g_shr
         assign dn_t = {{SHR{1'b0}}, src[W-1:SHR]} + kb;
      end
   endgenerate

   assign mid_t  = src + salt;
   assign mix    = up_t ^ mid_t ^ dn_t;
   assign result = sub ? (tgt - mix) : (tgt + mix);
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl #(
   parameter int ROUNDS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic busy,
   output logic phase,
   output logic done
);
   localparam int RC_W = $clog2(ROUNDS + 1);
   localparam logic [RC_W-1:0] RC_LAST = RC_W'(ROUNDS - 1);

   logic [RC_W-1:0] round_q;
   logic            last;

   assign load = start & ~busy;
   assign last = busy & phase & (round_q == RC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         phase   <= 1'b0;
         round_q <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy    <= 1'b1;
            phase   <= 1'b0;
            round_q <= '0;
         end else if (busy) begin
            phase <= ~phase;
            if (phase) round_q <= round_q + 1'b1;
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
   p_phase_toggles_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (phase != $past(phase)));
   p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));
endmodule

// File: rtl/fc_core.sv
module fc_core
   import feistel8_pkg::*;
#(
   parameter int W      = 8,
   parameter int SUM_W  = 16,
   parameter int ROUNDS = 8,
   parameter int DELTA  = 'h0A00,
   parameter int SHL    = 4,
   parameter int SHR    = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           busy,
   input  logic           phase,
   input  logic           fin,
   input  logic           decrypt,
   input  logic [2*W-1:0] block_in,
   input  logic [4*W-1:0] key_in,
   output logic [2*W-1:0] block_out
);
   localparam logic [SUM_W-1:0] STEP    = SUM_W'(DELTA);
   localparam logic [SUM_W-1:0] SUM_TOP = SUM_W'(DELTA * ROUNDS);

   logic [W-1:0]     v0_q, v1_q, src, tgt, ka, kb, upd;
   logic [4*W-1:0]   key_q;
   logic [W-1:0]     sk [4];
   logic [SUM_W-1:0] sum_q, sum_eff;
   op_e              op_q;
   logic             to_left;

   genvar gi;
   generate
      for (gi = 0; gi < 4; gi++) begin : g_subkey
         assign sk[gi] = key_q[(4-gi)*W-1 -: W];
      end
   endgenerate

   // encrypt writes left on phase 0, decrypt writes left on phase 1
   assign to_left = (phase == (op_q == OP_DEC));
   assign src     = to_left ? v1_q : v0_q;
   assign tgt     = to_left ? v0_q : v1_q;
   assign ka      = to_left ? sk[0] : sk[2];
   assign kb      = to_left ? sk[1] : sk[3];
   assign sum_eff = (op_q == OP_ENC && !phase) ? sum_q + STEP : sum_q;

   fc_mix #(.W(W), .SHL(SHL), .SHR(SHR)) i_mix (
      .src(src), .ka(ka), .kb(kb), .salt(sum_eff[W-1:0]),
      .tgt(tgt), .sub(op_q == OP_DEC), .result(upd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v0_q  <= '0;
         v1_q  <= '0;
         key_q <= '0;
         sum_q <= '0;
         op_q  <= OP_ENC;
      end else if (load) begin
         v0_q  <= block_in[2*W-1:W];
         v1_q  <= block_in[W-1:0];
         key_q <= key_in;
         op_q  <= op_e'(decrypt);
         sum_q <= decrypt ? SUM_TOP : '0;
      end else if (busy) begin
         if (to_left) v0_q <= upd;
         else         v1_q <= upd;
         if (op_q == OP_ENC && !phase) sum_q <= sum_q + STEP;
         if (op_q == OP_DEC &&  phase) sum_q <= sum_q - STEP;
      end
   end

   assign block_out = {v0_q, v1_q};

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> $stable(block_out));
   p_one_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (v0_q == $past(v0_q) || v1_q == $past(v1_q)));
   p_sum_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (sum_q == ((op_q == OP_DEC) ? '0 : SUM_TOP)));
   p_key_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> $stable(key_q));
endmodule

// File: rtl/feistel8_engine.sv
module feistel8_engine #(
   parameter int HALF_W = 8,
   parameter int SUM_W  = 16,
   parameter int ROUNDS = 8,
   parameter int DELTA  = 'h0A00,
   parameter int SHL    = 4,
   parameter int SHR    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                decrypt,
   input  logic [2*HALF_W-1:0] block_in,
   input  logic [4*HALF_W-1:0] key_in,
   output logic [2*HALF_W-1:0] block_out,
   output logic                done
);
   generate
      if (SHL >= HALF_W || SHR >= HALF_W) begin : g_bad_shift
         $error("shift amounts must be below the half width");
      end
      if (SUM_W < HALF_W) begin : g_bad_sum
         $error("sum must be at least as wide as a half");
      end
      if (ROUNDS < 1) begin : g_bad_rounds
         $error("at least one round is required");
      end
   endgenerate

   logic load, busy, phase;

   fc_ctrl #(.ROUNDS(ROUNDS)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .load(load),
      .busy(busy), .phase(phase), .done(done)
   );

   fc_core #(
      .W(HALF_W), .SUM_W(SUM_W), .ROUNDS(ROUNDS), .DELTA(DELTA),
      .SHL(SHL), .SHR(SHR)
   ) i_core (
      .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .phase(phase),
      .fin(done), .decrypt(decrypt), .block_in(block_in), .key_in(key_in),
      .block_out(block_out)
   );

   p_start_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !done || $past(phase));
endmodule

// File: tb/test_feistel8_engine.sv
module test_feistel8_engine;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        decrypt = 1'b0;
   logic [15:0] block_in = '0;
   logic [31:0] key_in = '0;
   logic [15:0] block_out;
   logic        done;

   int vectors = 0;
   int miscompares = 0;

   feistel8_engine i_feistel8_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
      .block_in(block_in), .key_in(key_in), .block_out(block_out), .done(done)
   );

   always #(PERIOD/2) clk = ~clk;

   // reference model, stepped behaviourally per clock
   logic [7:0]  m_l, m_r;
   logic [31:0] m_key;
   logic        m_dec, m_busy, m_done;
   int          m_step;
   int          m_sum;

   function automatic logic [7:0] f_mix(logic [7:0] x, logic [7:0] a,
                                        logic [7:0] b, int s);
      logic [7:0] p, q, r;
      p = 8'((x * 16) % 256) + a;
      q = x + 8'(s % 256);
      r = 8'(x / 32) + b;
      return p ^ q ^ r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_l = 0; m_r = 0; m_key = 0; m_dec = 0;
         m_busy = 0; m_done = 0; m_step = 0; m_sum = 0;
      end else begin
         m_done = 0;
         if (start && !m_busy) begin
            m_l = block_in[15:8]; m_r = block_in[7:0];
            m_key = key_in; m_dec = decrypt;
            m_busy = 1; m_step = 0;
            m_sum = decrypt ? 'h5000 : 0;
         end else if (m_busy) begin
            if (!m_dec) begin
               if (m_step % 2 == 0) begin
                  m_sum = (m_sum + 'h0A00) % 65536;
                  m_l = m_l + f_mix(m_r, m_key[31:24], m_key[23:16], m_sum);
               end else
                  m_r = m_r + f_mix(m_l, m_key[15:8], m_key[7:0], m_sum);
            end else begin
               if (m_step % 2 == 0)
                  m_r = m_r - f_mix(m_l, m_key[15:8], m_key[7:0], m_sum);
               else begin
                  m_l = m_l - f_mix(m_r, m_key[31:24], m_key[23:16], m_sum);
                  m_sum = (m_sum + 65536 - 'h0A00) % 65536;
               end
            end
            m_step++;
            if (m_step == 16) begin
               m_busy = 0; m_done = 1;
            end
         end
      end
   end

   // per-clock comparison against the model (R4 ordering and shifts)
   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (block_out !== {m_l, m_r} || done !== m_done) begin
            miscompares++;
            $display("FAIL R4 model: actual %h/%b expected %h/%b",
                     block_out, done, {m_l, m_r}, m_done);
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   logic [15:0] snap [18];
   int          done_at;
   int          done_cnt;

   // disturb: 0 none, 1 start pulse with other inputs at clock 5, 2 inputs change only
   task automatic run_op(input logic dec, input logic [15:0] blk,
                         input logic [31:0] key, input int disturb);
      @(negedge clk);
      decrypt = dec; block_in = blk; key_in = key; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      snap[0] = block_out;
      done_at = -1; done_cnt = 0;
      for (int c = 1; c < 18; c++) begin
         @(negedge clk);
         snap[c] = block_out;
         if (done) begin
            done_cnt++;
            if (done_at < 0) done_at = c;
         end
         if (c == 5 && disturb != 0) begin
            block_in = ~blk; key_in = ~key; decrypt = ~dec;
            if (disturb == 1) start = 1'b1;
         end
         if (c == 6) start = 1'b0;
      end
   endtask

   initial begin
      #(PERIOD * 150000);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [15:0] ct;
      logic [15:0] pt;
      logic [31:0] ky;
      #(PERIOD * 2 + 2);
      check("R1 reset out", 32'(block_out), 32'h0);
      check("R1 reset done", 32'(done), 32'h0);
      rst_n = 1'b1;

      run_op(1'b0, 16'h1234, 32'h778CAE38, 0);
      check("R4 left first", 32'(snap[1]), 32'h2034);
      check("R3 first round", 32'(snap[2]), 32'h20EB);
      check("R2 ciphertext", 32'(snap[16]), 32'hFD58);
      check("R6 done clock", 32'(done_at), 32'd16);
      check("R6 done width", 32'(done_cnt), 32'd1);
      repeat (8) @(negedge clk);
      check("R8 hold", 32'(block_out), 32'hFD58);

      run_op(1'b1, 16'hFD58, 32'h778CAE38, 0);
      check("R5 right first", 32'(snap[1][15:8]), 32'hFD);
      check("R5 plaintext", 32'(snap[16]), 32'h1234);
      check("R6 done clock dec", 32'(done_at), 32'd16);

      run_op(1'b0, 16'h1234, 32'h778CAE38, 1);
      check("R7 start ignored", 32'(snap[17]), 32'hFD58);
      check("R7 done clock", 32'(done_at), 32'd16);

      run_op(1'b0, 16'h1234, 32'h778CAE38, 2);
      check("R9 inputs captured", 32'(snap[17]), 32'hFD58);

      for (int i = 0; i < 12; i++) begin
         pt = 16'($urandom); ky = $urandom;
         run_op(1'b0, pt, ky, 0);
         ct = snap[16];
         run_op(1'b1, ct, ky, 0);
         check("R5 round trip", 32'(snap[16]), 32'(pt));
      end

      run_op(1'b0, 16'hFFFF, 32'hFFFFFFFF, 0);
      run_op(1'b0, 16'h0000, 32'h00000000, 0);

      // R1: asynchronous reset during an operation
      @(negedge clk);
      block_in = 16'hA5C3; key_in = 32'h0123ABCD; decrypt = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      #(PERIOD/4) rst_n = 1'b0;
      #1;
      check("R1 async out", 32'(block_out), 32'h0);
      check("R1 async done", 32'(done), 32'h0);
      @(negedge clk);
      #(PERIOD/4) rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 stays idle", 32'(block_out), 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule